// File: doc/BRIEF.md
# PLL Dynamic-Update Handshake Controller

This block sits on the register side of a fractional-N PLL. It lets software change the output frequency without stopping the oscillator. Software first writes a staged integer multiplier and a staged fractional word through a small register bus. It then sets an update request bit in the mode register. After a guard delay, the controller copies the staged words into the active copies that drive the PLL. On the same clock edge it raises a latch acknowledge.

A bypass bit selects who ends the handshake. With bypass clear, the controller clears the request itself when the acknowledge rises. With bypass set, the request stays high until software writes it back to zero. In both cases the acknowledge falls one cycle after the request has dropped, and that fall marks the update as complete. Each capture, and each rise of the enable, starts a programmable settle interval. During that interval the lock flag is held low.

When the PLL is disabled, a request takes the staged words at once and gives no acknowledge. A request that is set while a handshake is still running is discarded.

Top module: `pll_dynupd_ctrl`

## Requirements
- R1: After reset, all three registers read 0, and the active multiplier and fraction outputs, the acknowledge, the lock flag and the enable output are all 0.
- R2: Writes to the staged multiplier (address 1) and staged fraction (address 2) read back at once. They leave the active outputs unchanged until a capture happens.
- R3: Mode register bits are as follows: bit 0 is the enable, bits [15:8] are the settle count N, bit 22 is the request and bit 23 is the bypass. With enable=1 and bypass=0, a write that sets bit 22 makes the acknowledge rise exactly 2 cycles after the write edge. On that same edge bit 22 is cleared, and the acknowledge stays high for exactly one cycle.
- R4: With bypass=1, bit 22 stays 1 and the acknowledge stays high until software writes bit 22 to 0. The acknowledge falls one cycle after that write edge.
- R5: The active outputs change on the edge that raises the acknowledge and never earlier. The acknowledge never rises less than 2 cycles after the request rises.
- R6: A write that sets bit 22 with bit 0 written as 0 captures the staged words on that write edge. Bit 22 then reads 0 and the acknowledge stays low.
- R7: A write that sets bit 22 while a handshake is still in progress is dropped. Bit 22 reads 0 and no further acknowledge follows.
- R8: After a capture while enabled, the lock flag (output and mode bit 31) is low for N cycles and then high. With N=0 it stays high.
- R9: Bit 30 and the enable output follow bit 0. After a write that raises the enable, lock stays low for N+1 cycles and then rises.
- R10: Mode bits 20 and 21 are plain read/write storage. Bit 28 reads 0. Bit 29 mirrors the acknowledge and ignores writes. Address 3 reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data (combinational on address) |
| pll_mult_o | output | MULT_W | Active integer multiplier |
| pll_frac_o | output | FRAC_W | Active fractional word |
| pll_en_o | output | 1 | PLL enable |
| latch_ack_o | output | 1 | Latch acknowledge |
| lock_o | output | 1 | Lock flag |

## Verification
The hardest case to reach is a second request that lands in the single cycle in which an auto-cleared handshake still holds the acknowledge high. The request bit already reads 0 by then, so from the bus it looks idle. The stimulus drives a fresh set-request write on exactly the edge after the acknowledge is first seen. It then checks that bit 22 stays 0 and that no second acknowledge appears. Randomized updates with random bypass, settle count and software hold time cover the other interleavings of acknowledge, request clear and settle expiry.

// File: rtl/pll_upd_pkg.sv
`timescale 1ns/1ps
package pll_upd_pkg;
  localparam int BIT_EN       = 0;
  localparam int CFG_LO       = 8;
  localparam int BIT_FSM_EN   = 20;
  localparam int BIT_VOTE_RST = 21;
  localparam int BIT_REQ      = 22;
  localparam int BIT_BYP      = 23;
  localparam int BIT_OFFL     = 28;
  localparam int BIT_ACK      = 29;
  localparam int BIT_ACT      = 30;
  localparam int BIT_LOCK     = 31;

  localparam logic [1:0] ADR_MODE = 2'd0;
  localparam logic [1:0] ADR_MULT = 2'd1;
  localparam logic [1:0] ADR_FRAC = 2'd2;

  typedef enum logic [1:0] {
    HS_IDLE = 2'd0,
    HS_WAIT = 2'd1,
    HS_ACK  = 2'd2
  } hs_state_e;
endpackage

// File: rtl/pll_upd_regs.sv
`timescale 1ns/1ps
module pll_upd_regs
  import pll_upd_pkg::*;
#(
  parameter int MULT_W   = 16,
  parameter int FRAC_W   = 24,
  parameter int SETTLE_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en_i,
  input  logic [1:0]          addr_i,
  input  logic [31:0]         wdata_i,
  output logic [31:0]         rdata_o,
  input  logic                busy_i,
  input  logic                ack_i,
  input  logic                lock_i,
  input  logic                capture_i,
  input  logic                clr_req_i,
  output logic                start_hs_o,
  output logic                start_quick_o,
  output logic                en_o,
  output logic                byp_o,
  output logic                req_o,
  output logic [SETTLE_W-1:0] settle_cfg_o,
  output logic [MULT_W-1:0]   act_mult_o,
  output logic [FRAC_W-1:0]   act_frac_o
);

  logic                en_q, en_d;
  logic                fsm_en_q, fsm_en_d;
  logic                vote_q, vote_d;
  logic                req_q, req_d;
  logic                byp_q, byp_d;
  logic [SETTLE_W-1:0] cfg_q, cfg_d;
  logic [MULT_W-1:0]   stg_mult_q, stg_mult_d;
  logic [FRAC_W-1:0]   stg_frac_q, stg_frac_d;
  logic [MULT_W-1:0]   act_mult_q, act_mult_d;
  logic [FRAC_W-1:0]   act_frac_q, act_frac_d;

  logic wr_mode, wr_mult, wr_frac, req_set_try;
  logic [31:0] mode_rd;

  assign wr_mode = wr_en_i && (addr_i == ADR_MODE);
  assign wr_mult = wr_en_i && (addr_i == ADR_MULT);
  assign wr_frac = wr_en_i && (addr_i == ADR_FRAC);

  // A set of the request counts only as a fresh rising edge when idle
  assign req_set_try   = wr_mode & wdata_i[BIT_REQ] & ~req_q & ~busy_i;
  assign start_hs_o    = req_set_try &  wdata_i[BIT_EN];
  assign start_quick_o = req_set_try & ~wdata_i[BIT_EN];

  always_comb begin
    en_d       = en_q;
    fsm_en_d   = fsm_en_q;
    vote_d     = vote_q;
    req_d      = req_q;
    byp_d      = byp_q;
    cfg_d      = cfg_q;
    stg_mult_d = stg_mult_q;
    stg_frac_d = stg_frac_q;
    act_mult_d = act_mult_q;
    act_frac_d = act_frac_q;
    if (wr_mode) begin
      en_d     = wdata_i[BIT_EN];
      fsm_en_d = wdata_i[BIT_FSM_EN];
      vote_d   = wdata_i[BIT_VOTE_RST];
      byp_d    = wdata_i[BIT_BYP];
      cfg_d    = wdata_i[CFG_LO +: SETTLE_W];
      // keep a held request; accept a new one only when idle and enabled
      req_d    = wdata_i[BIT_REQ] & (req_q | (~busy_i & wdata_i[BIT_EN]));
    end
    if (clr_req_i) begin
      req_d = 1'b0;
    end
    if (wr_mult) begin
      stg_mult_d = wdata_i[MULT_W-1:0];
    end
    if (wr_frac) begin
      stg_frac_d = wdata_i[FRAC_W-1:0];
    end
    if (capture_i) begin
      act_mult_d = stg_mult_q;
      act_frac_d = stg_frac_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q       <= 1'b0;
      fsm_en_q   <= 1'b0;
      vote_q     <= 1'b0;
      req_q      <= 1'b0;
      byp_q      <= 1'b0;
      cfg_q      <= '0;
      stg_mult_q <= '0;
      stg_frac_q <= '0;
      act_mult_q <= '0;
      act_frac_q <= '0;
    end else begin
      en_q       <= en_d;
      fsm_en_q   <= fsm_en_d;
      vote_q     <= vote_d;
      req_q      <= req_d;
      byp_q      <= byp_d;
      cfg_q      <= cfg_d;
      stg_mult_q <= stg_mult_d;
      stg_frac_q <= stg_frac_d;
      act_mult_q <= act_mult_d;
      act_frac_q <= act_frac_d;
    end
  end

  always_comb begin
    mode_rd                      = '0;
    mode_rd[BIT_EN]              = en_q;
    mode_rd[CFG_LO +: SETTLE_W]  = cfg_q;
    mode_rd[BIT_FSM_EN]          = fsm_en_q;
    mode_rd[BIT_VOTE_RST]        = vote_q;
    mode_rd[BIT_REQ]             = req_q;
    mode_rd[BIT_BYP]             = byp_q;
    mode_rd[BIT_OFFL]            = 1'b0;
    mode_rd[BIT_ACK]             = ack_i;
    mode_rd[BIT_ACT]             = en_q;
    mode_rd[BIT_LOCK]            = lock_i;
  end

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      ADR_MODE: rdata_o = mode_rd;
      ADR_MULT: rdata_o[MULT_W-1:0] = stg_mult_q;
      ADR_FRAC: rdata_o[FRAC_W-1:0] = stg_frac_q;
      default:  rdata_o = '0;
    endcase
  end

  assign en_o         = en_q;
  assign byp_o        = byp_q;
  assign req_o        = req_q;
  assign settle_cfg_o = cfg_q;
  assign act_mult_o   = act_mult_q;
  assign act_frac_o   = act_frac_q;

  AST_ACTIVE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !capture_i |=> ($stable(act_mult_q) && $stable(act_frac_q))); // R2
  AST_BUSY_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_mode && !req_q && busy_i) |=> !req_q); // R7

endmodule

// File: rtl/pll_upd_fsm.sv
`timescale 1ns/1ps
module pll_upd_fsm
  import pll_upd_pkg::*;
#(
  parameter int ACK_DLY = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_hs_i,
  input  logic start_quick_i,
  input  logic req_i,
  input  logic byp_i,
  output logic capture_o,
  output logic clr_req_o,
  output logic busy_o,
  output logic ack_o
);

  localparam int CNT_W = $clog2(ACK_DLY) + 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(ACK_DLY - 1);

  hs_state_e        state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             hs_capture;

  always_comb begin
    state_d    = state_q;
    cnt_d      = cnt_q;
    hs_capture = 1'b0;
    clr_req_o  = 1'b0;
    case (state_q)
      HS_IDLE: begin
        if (start_hs_i) begin
          state_d = HS_WAIT;
          cnt_d   = '0;
        end
      end
      HS_WAIT: begin
        if (cnt_q == CNT_LAST) begin
          hs_capture = 1'b1;
          clr_req_o  = ~byp_i;
          state_d    = HS_ACK;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      HS_ACK: begin
        if (!req_i) begin
          state_d = HS_IDLE;
        end
      end
      default: state_d = HS_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= HS_IDLE;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end

  assign capture_o = hs_capture | start_quick_i;
  assign busy_o    = (state_q != HS_IDLE);
  assign ack_o     = (state_q == HS_ACK);

  AST_ACK_NOT_EARLY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ack_o) |-> ($past(req_i) && $past(req_i, 2))); // R5
  AST_AUTO_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(ack_o) && !$past(byp_i)) |-> !req_i); // R3
  AST_BYPASS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(ack_o) && $past(byp_i)) |-> req_i); // R4
  AST_ACK_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ack_o) |-> !$past(req_i)); // R4
  AST_QUICK_NO_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    start_quick_i |=> !ack_o); // R6

endmodule

// File: rtl/pll_upd_settle.sv
`timescale 1ns/1ps
module pll_upd_settle #(
  parameter int SETTLE_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                en_i,
  input  logic                capture_i,
  input  logic [SETTLE_W-1:0] cfg_i,
  output logic                lock_o
);

  logic [SETTLE_W-1:0] cnt_q, cnt_d;
  logic                en_prev_q;
  logic                reload;

  assign reload = en_i & (capture_i | ~en_prev_q);

  always_comb begin
    cnt_d = cnt_q;
    if (reload) begin
      cnt_d = cfg_i;
    end else if (cnt_q != '0) begin
      cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q     <= '0;
      en_prev_q <= 1'b0;
    end else begin
      cnt_q     <= cnt_d;
      en_prev_q <= en_i;
    end
  end

  assign lock_o = en_i & en_prev_q & (cnt_q == '0);

  AST_LOCK_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (capture_i && en_i && (cfg_i != '0)) |=> !lock_o); // R8
  AST_LOCK_ZERO_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_o && capture_i && en_i && (cfg_i == '0)) |=> lock_o); // R8

endmodule

// File: rtl/pll_dynupd_ctrl.sv
`timescale 1ns/1ps
module pll_dynupd_ctrl #(
  parameter int MULT_W   = 16,
  parameter int FRAC_W   = 24,
  parameter int SETTLE_W = 8,
  parameter int ACK_DLY  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [1:0]        bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic [MULT_W-1:0] pll_mult_o,
  output logic [FRAC_W-1:0] pll_frac_o,
  output logic              pll_en_o,
  output logic              latch_ack_o,
  output logic              lock_o
);

  logic                start_hs, start_quick, capture, clr_req;
  logic                busy, ack, lock, en, byp, req;
  logic [SETTLE_W-1:0] settle_cfg;

  pll_upd_regs #(
    .MULT_W  (MULT_W),
    .FRAC_W  (FRAC_W),
    .SETTLE_W(SETTLE_W)
  ) u_regs (
    .clk          (clk),
    .rst_n        (rst_n),
    .wr_en_i      (bus_wr),
    .addr_i       (bus_addr),
    .wdata_i      (bus_wdata),
    .rdata_o      (bus_rdata),
    .busy_i       (busy),
    .ack_i        (ack),
    .lock_i       (lock),
    .capture_i    (capture),
    .clr_req_i    (clr_req),
    .start_hs_o   (start_hs),
    .start_quick_o(start_quick),
    .en_o         (en),
    .byp_o        (byp),
    .req_o        (req),
    .settle_cfg_o (settle_cfg),
    .act_mult_o   (pll_mult_o),
    .act_frac_o   (pll_frac_o)
  );

  pll_upd_fsm #(
    .ACK_DLY(ACK_DLY)
  ) u_fsm (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_hs_i   (start_hs),
    .start_quick_i(start_quick),
    .req_i        (req),
    .byp_i        (byp),
    .capture_o    (capture),
    .clr_req_o    (clr_req),
    .busy_o       (busy),
    .ack_o        (ack)
  );

  pll_upd_settle #(
    .SETTLE_W(SETTLE_W)
  ) u_settle (
    .clk      (clk),
    .rst_n    (rst_n),
    .en_i     (en),
    .capture_i(capture),
    .cfg_i    (settle_cfg),
    .lock_o   (lock)
  );

  assign pll_en_o    = en;
  assign latch_ack_o = ack;
  assign lock_o      = lock;

endmodule

// File: tb/pll_dynupd_ctrl_tb.sv
`timescale 1ns/1ps
module pll_dynupd_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_wr;
  logic [1:0]  bus_addr;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic [15:0] pll_mult;
  logic [23:0] pll_frac;
  logic        pll_en, ack, lock;

  int  n_chk  = 0;
  int  n_fail = 0;
  bit  finished = 1'b0;

  logic [15:0] exp_mult;
  logic [23:0] exp_frac;

  always #2.5 clk = ~clk;

  pll_dynupd_ctrl u_dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_wr     (bus_wr),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .bus_rdata  (bus_rdata),
    .pll_mult_o (pll_mult),
    .pll_frac_o (pll_frac),
    .pll_en_o   (pll_en),
    .latch_ack_o(ack),
    .lock_o     (lock)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] mw(input bit en, input int cfg, input bit byp, input bit req);
    return 32'(en) | (32'(cfg & 8'hff) << 8) | (32'(byp) << 23) | (32'(req) << 22);
  endfunction

  // called at a negedge; the write lands on the next posedge
  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    bus_addr = a;
    #0.5;
    d = bus_rdata;
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_update(input logic [15:0] m, input logic [23:0] f, input bit byp,
                           input int n, input int hold, input bit exact);
    logic [31:0] r;
    wr(2'd1, {16'h0, m});
    wr(2'd2, {8'h0, f});
    chk("R2 staged mult not forwarded", pll_mult, exp_mult);
    chk("R2 staged frac not forwarded", pll_frac, exp_frac);
    rd(2'd1, r); chk("R2 staged mult readback", r, {16'h0, m});
    wr(2'd0, mw(1'b1, n, byp, 1'b1));                     // after T0
    rd(2'd0, r); chk("R3 request bit set", r[22], 1'b1);
    chk("R5 no ack at T0", ack, 1'b0);
    chk("R5 output held at T0", pll_mult, exp_mult);
    step(1);                                               // after T1
    chk("R5 no ack at T1", ack, 1'b0);
    chk("R5 frac held at T1", pll_frac, exp_frac);
    step(1);                                               // after T2
    exp_mult = m; exp_frac = f;
    chk("R3 ack at T2", ack, 1'b1);
    chk("R5 mult captured", pll_mult, exp_mult);
    chk("R5 frac captured", pll_frac, exp_frac);
    chk("R8 lock after capture", lock, (n == 0) ? 1'b1 : 1'b0);
    rd(2'd0, r);
    chk("R10 ack bit mirrors", r[29], 1'b1);
    if (!byp) begin
      chk("R3 auto clear of request", r[22], 1'b0);
      step(1);
      chk("R3 ack single cycle", ack, 1'b0);
      if (exact) begin
        for (int k = 1; k < n; k++) begin
          chk("R8 lock low while settling", lock, 1'b0);
          step(1);
        end
        chk("R8 lock back after settle", lock, 1'b1);
      end
    end else begin
      chk("R4 request held in bypass", r[22], 1'b1);
      step(hold);
      chk("R4 ack held in bypass", ack, 1'b1);
      wr(2'd0, mw(1'b1, n, 1'b1, 1'b0));
      chk("R4 ack still high on clear edge", ack, 1'b1);
      rd(2'd0, r); chk("R4 request cleared by software", r[22], 1'b0);
      step(1);
      chk("R4 ack falls after request", ack, 1'b0);
    end
    step(n + 2);
    chk("R8 lock after settle", lock, 1'b1);
    rd(2'd0, r); chk("R8 lock bit", r[31], 1'b1);
  endtask

  initial begin
    #1000000;
    if (!finished) begin
      n_fail++;
      $display("FAIL R1 watchdog actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    void'($urandom(32'h5eed_1234));
    rst_n = 1'b0; bus_wr = 1'b0; bus_addr = 2'd0; bus_wdata = '0;
    exp_mult = '0; exp_frac = '0;
    step(3);
    rst_n = 1'b1;
    step(1);

    // R1 reset state
    rd(2'd0, r); chk("R1 mode reset", r, 32'h0);
    rd(2'd1, r); chk("R1 mult reset", r, 32'h0);
    rd(2'd2, r); chk("R1 frac reset", r, 32'h0);
    chk("R1 outputs reset", {pll_mult, pll_frac, pll_en, ack, lock}, '0);

    // R10 plain storage and read-only bits
    wr(2'd0, (32'h1 << 20) | (32'h1 << 21) | (32'h1 << 28) | (32'h1 << 29) | (32'h5 << 8));
    rd(2'd0, r); chk("R10 mode map", r, (32'h1 << 20) | (32'h1 << 21) | (32'h5 << 8));
    rd(2'd3, r); chk("R10 address 3", r, 32'h0);
    wr(2'd0, 32'h0);

    // R6 disabled request captures at once
    wr(2'd1, 32'h1234);
    wr(2'd2, 32'hABCDE);
    chk("R2 no forward while disabled", pll_mult, 16'h0);
    wr(2'd0, mw(1'b0, 0, 1'b0, 1'b1));
    exp_mult = 16'h1234; exp_frac = 24'hABCDE;
    chk("R6 mult immediate", pll_mult, exp_mult);
    chk("R6 frac immediate", pll_frac, exp_frac);
    rd(2'd0, r); chk("R6 request reads 0", r[22], 1'b0);
    for (int k = 0; k < 4; k++) begin
      chk("R6 no ack", ack, 1'b0);
      step(1);
    end

    // R9 enable and initial settle, N=3
    wr(2'd0, mw(1'b1, 3, 1'b0, 1'b0));
    chk("R9 enable output", pll_en, 1'b1);
    rd(2'd0, r); chk("R9 active bit", r[30], 1'b1);
    for (int k = 0; k <= 3; k++) begin
      chk("R9 lock low after enable", lock, 1'b0);
      step(1);
    end
    chk("R9 lock rises at N+1", lock, 1'b1);

    // R3 / R8 directed exact timing
    do_update(16'h0042, 24'h000777, 1'b0, 3, 0, 1'b1);
    do_update(16'h0017, 24'h0A0A0A, 1'b0, 1, 0, 1'b1);

    // R7 request during the ack cycle is dropped, N=0
    wr(2'd1, 32'h0055);
    wr(2'd2, 32'h00BEEF);
    wr(2'd0, mw(1'b1, 0, 1'b0, 1'b1));
    step(2);
    exp_mult = 16'h0055; exp_frac = 24'h00BEEF;
    chk("R7 ack before retrigger", ack, 1'b1);
    chk("R8 lock held with N=0", lock, 1'b1);
    wr(2'd0, mw(1'b1, 0, 1'b0, 1'b1));
    rd(2'd0, r); chk("R7 retrigger dropped", r[22], 1'b0);
    for (int k = 0; k < 4; k++) begin
      chk("R7 no second ack", ack, 1'b0);
      step(1);
    end
    chk("R7 outputs unchanged", pll_mult, exp_mult);

    // R4 directed bypass
    do_update(16'h00F0, 24'h123456, 1'b1, 2, 3, 1'b0);

    // random mix
    for (int i = 0; i < 20; i++) begin
      do_update(16'($urandom()), 24'($urandom()), 1'($urandom() & 1),
                int'($urandom() % 8), int'($urandom() % 5), 1'b0);
    end

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule